// File: doc/BRIEF.md
# Ring-Oscillator Differential Thermal Counter

This block turns two free-running ring-oscillator signals into a single temperature-dependent number. When a measurement is started it opens a window of a fixed number of tile-clock cycles, counts the rising edges of each oscillator inside that window, and reports the first count minus the second as a signed counter value. A larger value means a colder die, because the reported value falls linearly as temperature rises.

The window is defined in real time. Software writes a base cycle count that applies when the tile clock runs at divide-by-2, the fastest setting. The block also takes the current tile clock divider, which ranges from 2 to 16, and rescales the base count by 2/divider. As a result, one window has the same duration at any divider setting. Each oscillator input is resynchronised into the tile clock domain before its edges are counted.

Top module: `thermal_ro_diff_counter`

## Requirements
- R1: After reset `cv_out` is 0 and `cv_valid` is low.
- R2: A start accepted at clock edge E opens a window of N cycles. `cv_valid` goes high on edge E+N+1 and stays high for exactly one cycle. `cv_out` carries the new result from that same edge.
- R3: N equals floor(2 × base / d). Here base is the value held by the base-count register, and d is `div_sel` clamped to the range 2..16, so 0 and 1 act as 2 and values above 16 act as 16. If the quotient is 0, N is 1.
- R4: Each oscillator passes through a two-flop synchronizer, and its rising edges are counted. A rise first sampled high at clock edge k is counted in a window opened at edge E when E−1 ≤ k ≤ E+N−2.
- R5: `cv_out` is count(`osc_a`) − count(`osc_b`) as a 16-bit two's-complement value.
- R6: A difference above 32767 is reported as 32767 (0x7FFF). A difference below −32768 is reported as −32768 (0x8000).
- R7: A start sampled while a window is open, or on the reporting edge E+N+1, is ignored: it produces no extra result and does not change the current one. A start sampled on edge E+N+2, while `cv_valid` is high, is accepted.
- R8: The base count and the divider are captured when a start is accepted. A base-count write or a `div_sel` change during a window does not alter that window's length.
- R9: `cv_out` holds its value in every cycle in which `cv_valid` is low.
- R10: A write with `cfg_we` high loads `cfg_base` into the base-count register on that edge, and the next start uses it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tile clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the base-count register |
| cfg_base | input | CYC_W (18) | Window length in cycles at divide-by-2 |
| div_sel | input | DIV_W (5) | Current tile clock divider, 2..16 |
| start | input | 1 | One-cycle measurement request |
| osc_a | input | 1 | First ring-oscillator signal (asynchronous) |
| osc_b | input | 1 | Second ring-oscillator signal (asynchronous) |
| cv_out | output | CV_W (16) | Signed, saturated count difference |
| cv_valid | output | 1 | One-cycle strobe marking a new result |

## Verification
The end of one window and a new start request can fall into adjacent edges. A start that lands on the reporting edge must be dropped, while a start held one edge longer, into the cycle where `cv_valid` is high, must open the next window. The bench holds a start across both edges. The scoreboard then expects exactly two results: the first at its normal edge, and the second from a window opened on the later edge. Any third result, or any shift in timing, is flagged. A base-count write and a divider change issued in the same cycle as a mid-window start are judged the same way: the window must keep its original length.

// File: rtl/thermal_cnt_pkg.sv
// Package: shared constants and the measurement state type for the
// differential thermal counter. Assumes a divider range of 2..16 and
// exactly two oscillator channels.
package thermal_cnt_pkg;
    localparam int DIV_FLOOR = 2;
    localparam int DIV_CEIL  = 16;
    localparam int NUM_OSC   = 2;

    typedef enum logic [1:0] {
        MS_IDLE   = 2'd0,
        MS_RUN    = 2'd1,
        MS_REPORT = 2'd2
    } meas_state_e;
endpackage

// File: rtl/osc_edge_counter.sv
// osc_edge_counter: brings one asynchronous oscillator signal into the
// clock domain through two flops, detects rising edges and counts them
// while enabled. Assumes the oscillator is slower than half the clock.
module osc_edge_counter #(
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_in,
    input  logic             clr,
    input  logic             en,
    output logic [CNT_W-1:0] count
);
    logic meta_q;
    logic sync_q;
    logic prev_q;
    logic rise;

    // Two-flop synchronizer plus one delay flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= osc_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise = sync_q & ~prev_q;

    // Edge counter: cleared at window open, advanced on edges while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (en && rise) begin
            count <= count + 1'b1;
        end
    end

    // R4
    single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

    // R4
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(count));
endmodule

// File: rtl/window_scaler.sv
// window_scaler: converts the base window count (defined at divide-by-2)
// into the cycle count for the current divider: floor(2*base/div), with
// the divider clamped to 2..16 and a zero result raised to one.
// Purely combinational; the clock only serves the check.
module window_scaler
    import thermal_cnt_pkg::*;
#(
    parameter int CYC_W = 18,
    parameter int DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CYC_W-1:0] base_cycles,
    input  logic [DIV_W-1:0] div_sel,
    output logic [CYC_W:0]   eff_cycles
);
    localparam logic [DIV_W-1:0] D_LO = DIV_W'(DIV_FLOOR);
    localparam logic [DIV_W-1:0] D_HI = DIV_W'(DIV_CEIL);
    localparam int PAD_W = CYC_W + 1 - DIV_W;

    logic [DIV_W-1:0] div_c;
    logic [CYC_W:0]   num;
    logic [CYC_W:0]   quot;

    // Clamp the divider into its legal range.
    always_comb begin
        if (div_sel < D_LO)      div_c = D_LO;
        else if (div_sel > D_HI) div_c = D_HI;
        else                     div_c = div_sel;
    end

    assign num  = {base_cycles, 1'b0};
    assign quot = num / {{PAD_W{1'b0}}, div_c};

    // Never hand a zero-length window to the controller.
    assign eff_cycles = (quot == '0) ? {{CYC_W{1'b0}}, 1'b1} : quot;

    // R3
    scale_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (longint'(num) < longint'(div_c)) ? (eff_cycles == 1)
        : ((longint'(eff_cycles) * longint'(div_c) <= longint'(num)) &&
           (longint'(num) < (longint'(eff_cycles) + 1) * longint'(div_c))));
endmodule

// File: rtl/window_ctrl.sv
// window_ctrl: sequences one measurement. It accepts a start only when
// idle, runs for the captured number of cycles with counting enabled, then
// spends one cycle in a report state. Assumes eff_cycles is never zero.
module window_ctrl
    import thermal_cnt_pkg::*;
#(
    parameter int CYC_W = 18
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [CYC_W:0] eff_cycles,
    output logic           cnt_clr,
    output logic           cnt_en,
    output logic           report
);
    meas_state_e    state;
    logic [CYC_W:0] remaining;

    // Window state machine with a down-counter of cycles left.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= MS_IDLE;
            remaining <= '0;
        end else begin
            case (state)
                MS_IDLE: begin
                    if (start) begin
                        remaining <= eff_cycles;
                        state     <= MS_RUN;
                    end
                end
                MS_RUN: begin
                    remaining <= remaining - 1'b1;
                    if (remaining == 1) state <= MS_REPORT;
                end
                MS_REPORT: state <= MS_IDLE;
                default:   state <= MS_IDLE;
            endcase
        end
    end

    assign cnt_clr = (state == MS_IDLE) && start;
    assign cnt_en  = (state == MS_RUN);
    assign report  = (state == MS_REPORT);

    // R7
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MS_RUN && remaining > 1 && start) |=>
        (state == MS_RUN && remaining == $past(remaining) - 1'b1));

    // R7
    report_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MS_REPORT) |=> (state == MS_IDLE));
endmodule

// File: rtl/thermal_ro_diff_counter.sv
// thermal_ro_diff_counter: top level. It holds the base window register,
// rescales the window for the tile divider, counts both oscillators and
// reports their saturated difference with a one-cycle strobe.
// Assumes CYC_W + 1 > CV_W so saturation limits are representable.
module thermal_ro_diff_counter
    import thermal_cnt_pkg::*;
#(
    parameter int CYC_W    = 18,
    parameter int DIV_W    = 5,
    parameter int CV_W     = 16,
    parameter int BASE_RST = 400
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CYC_W-1:0] cfg_base,
    input  logic [DIV_W-1:0] div_sel,
    input  logic             start,
    input  logic             osc_a,
    input  logic             osc_b,
    output logic [CV_W-1:0]  cv_out,
    output logic             cv_valid
);
    localparam int CNT_W = CYC_W;
    localparam logic signed [CNT_W:0] POS_LIM = (CNT_W+1)'((1 << (CV_W - 1)) - 1);
    localparam logic signed [CNT_W:0] NEG_LIM = -POS_LIM - 1;

    logic [CYC_W-1:0]  base_q;
    logic [CYC_W:0]    eff_cycles;
    logic              cnt_clr;
    logic              cnt_en;
    logic              report;
    logic [NUM_OSC-1:0] osc_vec;
    logic [CNT_W-1:0]  ch_count [NUM_OSC];
    logic signed [CNT_W:0] diff;
    logic [CV_W-1:0]   sat_val;

    // Base window register, written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)      base_q <= CYC_W'(BASE_RST);
        else if (cfg_we) base_q <= cfg_base;
    end

    window_scaler #(.CYC_W(CYC_W), .DIV_W(DIV_W)) u_scaler (
        .clk         (clk),
        .rst_n       (rst_n),
        .base_cycles (base_q),
        .div_sel     (div_sel),
        .eff_cycles  (eff_cycles)
    );

    window_ctrl #(.CYC_W(CYC_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .eff_cycles (eff_cycles),
        .cnt_clr    (cnt_clr),
        .cnt_en     (cnt_en),
        .report     (report)
    );

    assign osc_vec = {osc_b, osc_a};

    for (genvar g = 0; g < NUM_OSC; g++) begin : g_ch
        osc_edge_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .osc_in (osc_vec[g]),
            .clr    (cnt_clr),
            .en     (cnt_en),
            .count  (ch_count[g])
        );
    end

    // Signed difference of the two channel counts, clipped to CV_W bits.
    always_comb begin
        diff = $signed({1'b0, ch_count[0]}) - $signed({1'b0, ch_count[1]});
        if (diff > POS_LIM)      sat_val = POS_LIM[CV_W-1:0];
        else if (diff < NEG_LIM) sat_val = NEG_LIM[CV_W-1:0];
        else                     sat_val = diff[CV_W-1:0];
    end

    // Result register and strobe, loaded in the report cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cv_out   <= '0;
            cv_valid <= 1'b0;
        end else begin
            cv_valid <= report;
            if (report) cv_out <= sat_val;
        end
    end

    // R2
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cv_valid |=> !cv_valid);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cv_valid |-> $stable(cv_out));
endmodule

// File: tb/thermal_ro_diff_counter_tb_top.sv
// Scoreboard bench: driver tasks push expected windows, a monitor pops
// them at each result and compares value and timing against a model
// built from the logged oscillator rises.
module thermal_ro_diff_counter_tb_top;
    localparam int CYC_W = 18;
    localparam int DIV_W = 5;
    localparam int CV_W  = 16;
    localparam int MAXC  = 200000;
    localparam int WDOG  = 190000;

    typedef struct {
        int    e0;
        int    n;
        string tag_v;
        string tag_t;
    } exp_item_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [CYC_W-1:0] cfg_base = '0;
    logic [DIV_W-1:0] div_sel = 5'd2;
    logic             start = 1'b0;
    logic             osc_a = 1'b0;
    logic             osc_b = 1'b0;
    logic [CV_W-1:0]  cv_out;
    logic             cv_valid;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int per_a    = 0;
    int per_b    = 0;
    int cum_a [0:MAXC];
    int cum_b [0:MAXC];
    int n_pushed = 0;
    int n_seen   = 0;
    int last_exp = 0;
    bit prev_valid = 1'b0;
    bit finished = 1'b0;
    exp_item_t sb_q [$];

    thermal_ro_diff_counter #(.CYC_W(CYC_W), .DIV_W(DIV_W), .CV_W(CV_W)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_base (cfg_base),
        .div_sel  (div_sel),
        .start    (start),
        .osc_a    (osc_a),
        .osc_b    (osc_b),
        .cv_out   (cv_out),
        .cv_valid (cv_valid)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc = cyc + 1;

    function automatic logic lvl(int m, int p);
        if (p == 0) return 1'b0;
        return (m % p) < (p / 2);
    endfunction

    function automatic int sat16(int v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic int win_len(int base, int d);
        int dc;
        int q;
        dc = (d < 2) ? 2 : ((d > 16) ? 16 : d);
        q  = (2 * base) / dc;
        return (q == 0) ? 1 : q;
    endfunction

    task automatic check(string req, bit ok, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Oscillator driver: level for edge m = cyc+1, with a cumulative log of rises.
    initial begin
        cum_a[0] = 0;
        cum_b[0] = 0;
    end

    always @(negedge clk) begin
        int m;
        logic na;
        logic nb;
        m  = cyc + 1;
        na = lvl(m, per_a);
        nb = lvl(m, per_b);
        if (m <= MAXC) begin
            cum_a[m] = cum_a[m-1] + ((na && !osc_a) ? 1 : 0);
            cum_b[m] = cum_b[m-1] + ((nb && !osc_b) ? 1 : 0);
        end
        osc_a = na;
        osc_b = nb;
    end

    // Monitor: pops an expected window at each result and compares.
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_valid) check("R2 one-cycle strobe", !cv_valid, int'(cv_valid), 0);
            if (cv_valid) begin
                n_seen++;
                if (sb_q.size() == 0) begin
                    check("R7 unexpected result", 1'b0, n_seen, n_pushed);
                end else begin
                    exp_item_t it;
                    int ca;
                    int cb;
                    int ev;
                    it = sb_q.pop_front();
                    ca = cum_a[it.e0 + it.n - 2] - cum_a[it.e0 - 2];
                    cb = cum_b[it.e0 + it.n - 2] - cum_b[it.e0 - 2];
                    ev = sat16(ca - cb);
                    last_exp = ev;
                    check(it.tag_v, int'($signed(cv_out)) == ev, int'($signed(cv_out)), ev);
                    check(it.tag_t, cyc == it.e0 + it.n + 1, cyc, it.e0 + it.n + 1);
                end
            end
        end
        prev_valid = cv_valid;
    end

    task automatic wait_idle();
        while (sb_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic launch(int base, int d, int pa, int pb, string tv, string tt);
        exp_item_t it;
        @(negedge clk);
        per_a    = pa;
        per_b    = pb;
        cfg_we   = 1'b1;
        cfg_base = CYC_W'(base);
        div_sel  = DIV_W'(d);
        @(negedge clk);
        cfg_we = 1'b0;
        start  = 1'b1;
        it.e0 = cyc + 1; it.n = win_len(base, d); it.tag_v = tv; it.tag_t = tt;
        sb_q.push_back(it);
        n_pushed++;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        while (cyc < WDOG) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, WDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        exp_item_t it;
        int e0;
        int n;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check("R1 reset cv_out", cv_out == '0, int'(cv_out), 0);
        check("R1 reset cv_valid", cv_valid == 1'b0, int'(cv_valid), 0);
        repeat (10) @(negedge clk);

        // Two oscillators at different rates (R4, R5, R10).
        launch(40, 2, 4, 6, "R4/R5 diff", "R10 window");
        wait_idle();
        launch(37, 2, 6, 4, "R5 negative diff", "R2 timing");
        wait_idle();
        launch(50, 2, 10, 2, "R4 fast b", "R2 timing");
        wait_idle();

        // Divider rescaling, truncation and clamping (R3).
        launch(40, 5, 4, 8, "R5 div5", "R3 div5");
        wait_idle();
        launch(40, 7, 6, 4, "R5 div7", "R3 div7 trunc");
        wait_idle();
        launch(30, 1, 4, 10, "R5 div clamp low", "R3 clamp low");
        wait_idle();
        launch(30, 25, 4, 10, "R5 div clamp high", "R3 clamp high");
        wait_idle();
        launch(0, 9, 2, 0, "R5 zero base", "R3 min window");
        wait_idle();

        // R9: result holds between strobes.
        repeat (20) @(negedge clk);
        check("R9 hold", int'($signed(cv_out)) == last_exp, int'($signed(cv_out)), last_exp);

        // R7/R8: start, config write and divider change inside a window.
        launch(40, 2, 4, 6, "R5 mid-window", "R8 length kept");
        repeat (3) @(negedge clk);
        start = 1'b1; cfg_we = 1'b1; cfg_base = CYC_W'(3); div_sel = 5'd16;
        @(negedge clk);
        start = 1'b0; cfg_we = 1'b0;
        wait_idle();
        repeat (60) @(negedge clk);
        check("R7 no extra result", n_seen == n_pushed, n_seen, n_pushed);

        // R7: start held over the report edge and the valid cycle.
        launch(10, 2, 4, 6, "R5 first of pair", "R7 first timing");
        e0 = sb_q[0].e0;
        n  = sb_q[0].n;
        while (cyc != e0 + n) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        it.e0 = cyc + 1; it.n = win_len(10, 2); it.tag_v = "R5 second of pair"; it.tag_t = "R7 accepted on valid";
        sb_q.push_back(it);
        n_pushed++;
        @(negedge clk);
        start = 1'b0;
        wait_idle();
        repeat (40) @(negedge clk);
        check("R7 pair count", n_seen == n_pushed, n_seen, n_pushed);

        // R6: saturation in both directions.
        launch(66000, 2, 2, 0, "R6 positive clip", "R2 long window");
        wait_idle();
        launch(66000, 2, 0, 2, "R6 negative clip", "R2 long window");
        wait_idle();

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule